// File: doc/BRIEF.md
# Parallel Input Channel Handshake Receiver

This block is the machine-side end of one parallel input channel. A peripheral raises either a data request or an interrupt line while it holds a word on the data lines. The block captures that word and tags it as a data word or an interrupt code. It then asks the core for one memory access and holds the word steady until the access is granted. After that it answers the peripheral with a single acknowledge pulse. Data requests are honoured only while the core has a buffer open on the channel. Interrupt codes are honoured at any time.

Three timing rules guard the handshake, and each is a clock-cycle parameter. The first is a floor on the delay from request to acknowledge. The second is a fixed acknowledge width. The third is a minimum time the request lines must spend low before a new request counts. A peripheral may raise its next request while the current acknowledge is still high. That request is served once the pulse ends, provided the low gap before it was long enough.

Top module: `inchan_rx`

## Requirements
- R1: The request and interrupt lines each pass through two synchronising flops. A line that rises before clock edge 1 is acted on at edge 3. The memory request output is low after edge 2 and high after edge 3, when no earlier transaction is pending.
- R2: While `buf_active_i` is low, a data request alone produces no memory request and no acknowledge, however long it is held.
- R3: An interrupt is accepted whether `buf_active_i` is high or low. Its captured word carries `mem_is_intr_o` = 1. A data word carries 0.
- R4: When the request and interrupt lines are both high at acceptance, the transaction is served as an interrupt, with `mem_is_intr_o` = 1.
- R5: `mem_word_o` takes the data lines at the acceptance edge. It keeps that value until the acknowledge pulse has ended, even if the data lines change.
- R6: `mem_req_o` stays high from acceptance until the first edge at which `mem_grant_i` is sampled high. It is low after that edge. A grant seen before acceptance is ignored.
- R7: Count edges from the acceptance edge E, and let G be the edge at which the grant is taken, with G no earlier than E+1. The acknowledge rises after edge max(E+MIN_DELAY_CYC+1, G+1).
- R8: `in_ack_o` stays high for exactly ACK_CYC clock cycles per transaction.
- R9: After a transaction has been accepted, another one is accepted only once the combined request/interrupt input has been low for at least GAP_CYC consecutive cycles. A shorter low interval is ignored.
- R10: A request that rises while the acknowledge is still high is served after the pulse ends, provided it followed a qualifying low gap.
- R11: After reset, `in_ack_o` and `mem_req_o` are low and the channel is ready to accept a request straight away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_data_i | input | DATA_W | Parallel data lines from the peripheral |
| in_req_i | input | 1 | Data word request from the peripheral (asynchronous) |
| in_intr_i | input | 1 | Interrupt code request from the peripheral (asynchronous) |
| buf_active_i | input | 1 | High while the core has an input buffer open on this channel |
| in_ack_o | output | 1 | Acknowledge to the peripheral, shared by data and interrupt |
| mem_req_o | output | 1 | Memory access request toward the core |
| mem_grant_i | input | 1 | Memory access grant from the core |
| mem_word_o | output | DATA_W | Captured word presented to the core |
| mem_is_intr_o | output | 1 | 1 when the captured word is an interrupt code |

## Verification
The bench builds the block with MIN_DELAY_CYC = 5, ACK_CYC = 6 and GAP_CYC = 3, so every timing window is only a few cycles long. With these values it can sweep every grant arrival from before acceptance to well past the delay floor, for both data and interrupt transactions, and predict the acknowledge edge from the max() rule. The short gap and the wide pulse let it try every low interval around the re-arm threshold. That includes re-raising the request in the middle of a live acknowledge.

// File: rtl/inchan_pkg.sv
package inchan_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_WAIT = 2'd1,
    RX_ACK  = 2'd2
  } rx_state_e;

endpackage

// File: rtl/inchan_sync.sv
module inchan_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/inchan_rearm.sv
module inchan_rearm #(
  parameter int GAP_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic take_i,
  output logic armed_o
);

  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [GW-1:0] GAP_MAX  = GW'(GAP_CYC);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);

  logic [GW-1:0] low_q, low_d;
  logic          low_en;
  logic          armed_q, armed_d;

  always_comb begin
    low_en = line_i || (low_q != GAP_MAX);
    low_d  = line_i ? '0 : low_q + 1'b1;
  end

  always_comb begin
    armed_d = armed_q;
    if (take_i)                              armed_d = 1'b0;
    else if (!line_i && low_q == GAP_LAST)   armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      if (low_en) low_q <= low_d;
      armed_q <= armed_d;
    end
  end

  assign armed_o = armed_q;

  // R9: a transaction is only taken while the channel is re-armed
  assert_take_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> armed_q);

  // R9: re-arming needs the line to be low
  assert_arm_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> !$past(line_i));

endmodule

// File: rtl/inchan_seq.sv
module inchan_seq
  import inchan_pkg::*;
#(
  parameter int MIN_DELAY_CYC = 1600,
  parameter int ACK_CYC       = 880
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic mem_grant_i,
  output logic capture_o,
  output logic mem_req_o,
  output logic ack_o
);

  localparam int DW = $clog2(MIN_DELAY_CYC + 1);
  localparam int AW = $clog2(ACK_CYC + 1);
  localparam logic [DW-1:0] DLY_MAX  = DW'(MIN_DELAY_CYC);
  localparam logic [AW-1:0] ACK_LAST = AW'(ACK_CYC - 1);

  rx_state_e     st_q, st_d;
  logic [DW-1:0] dly_q, dly_d;
  logic          dly_en;
  logic          gnt_q, gnt_d;
  logic [AW-1:0] ac_q, ac_d;
  logic          ac_en;

  always_comb begin
    st_d   = st_q;
    dly_d  = dly_q;
    dly_en = 1'b0;
    gnt_d  = gnt_q;
    ac_d   = ac_q;
    ac_en  = 1'b0;
    unique case (st_q)
      RX_IDLE: begin
        if (go_i) begin
          st_d   = RX_WAIT;
          dly_d  = '0;
          dly_en = 1'b1;
          gnt_d  = 1'b0;
        end
      end
      RX_WAIT: begin
        gnt_d = gnt_q | mem_grant_i;
        if (dly_q != DLY_MAX) begin
          dly_d  = dly_q + 1'b1;
          dly_en = 1'b1;
        end
        if (gnt_q && dly_q == DLY_MAX) begin
          st_d  = RX_ACK;
          ac_d  = '0;
          ac_en = 1'b1;
        end
      end
      RX_ACK: begin
        if (ac_q == ACK_LAST) begin
          st_d = RX_IDLE;
        end else begin
          ac_d  = ac_q + 1'b1;
          ac_en = 1'b1;
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      dly_q <= '0;
      gnt_q <= 1'b0;
      ac_q  <= '0;
    end else begin
      st_q  <= st_d;
      gnt_q <= gnt_d;
      if (dly_en) dly_q <= dly_d;
      if (ac_en)  ac_q  <= ac_d;
    end
  end

  assign capture_o = (st_q == RX_IDLE) && go_i;
  assign mem_req_o = (st_q == RX_WAIT) && !gnt_q;
  assign ack_o     = (st_q == RX_ACK);

  // R6: a sampled grant withdraws the memory request
  assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_grant_i) |=> !mem_req_o);

  // R6: never request memory while acknowledging
  assert_req_vs_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> !mem_req_o);

  // R7: the acknowledge only rises after grant and the full delay
  assert_ack_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> ($past(gnt_q) && $past(dly_q) == DLY_MAX));

  // R8: the acknowledge ends after the last count of its pulse
  assert_ack_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> ($past(ac_q) == ACK_LAST));

endmodule

// File: rtl/inchan_rx.sv
module inchan_rx #(
  parameter int DATA_W        = 30,
  parameter int MIN_DELAY_CYC = 1600,
  parameter int ACK_CYC       = 880,
  parameter int GAP_CYC       = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_req_i,
  input  logic              in_intr_i,
  input  logic              buf_active_i,
  output logic              in_ack_o,
  output logic              mem_req_o,
  input  logic              mem_grant_i,
  output logic [DATA_W-1:0] mem_word_o,
  output logic              mem_is_intr_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sh_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_q_n = rst_sh_q[1];

  logic [1:0] line_s;
  logic       req_s, intr_s, any_s;
  logic       armed, go, capture;

  inchan_sync #(.STAGES(2), .W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d_i   ({in_intr_i, in_req_i}),
    .q_o   (line_s)
  );

  assign req_s  = line_s[0];
  assign intr_s = line_s[1];
  assign any_s  = req_s | intr_s;
  assign go     = armed && (intr_s || (req_s && buf_active_i));

  inchan_rearm #(.GAP_CYC(GAP_CYC)) u_rearm (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .line_i  (any_s),
    .take_i  (capture),
    .armed_o (armed)
  );

  inchan_seq #(.MIN_DELAY_CYC(MIN_DELAY_CYC), .ACK_CYC(ACK_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .go_i        (go),
    .mem_grant_i (mem_grant_i),
    .capture_o   (capture),
    .mem_req_o   (mem_req_o),
    .ack_o       (in_ack_o)
  );

  logic [DATA_W-1:0] word_q, word_d;
  logic              tag_q, tag_d;

  always_comb begin
    word_d = in_data_i;
    tag_d  = intr_s;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      word_q <= '0;
      tag_q  <= 1'b0;
    end else if (capture) begin
      word_q <= word_d;
      tag_q  <= tag_d;
    end
  end

  assign mem_word_o    = word_q;
  assign mem_is_intr_o = tag_q;

  // R2: a data word is taken only with a buffer open
  assert_buf_gate_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (capture && !intr_s) |-> buf_active_i);

  // R5: the word stays put while the acknowledge is up
  assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_ack_o && $past(in_ack_o)) |-> $stable(mem_word_o));

  // R3: the tag stays put while memory is being requested
  assert_tag_hold_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mem_req_o && $past(mem_req_o)) |-> $stable(mem_is_intr_o));

endmodule

// File: tb/inchan_rx_test.sv
module inchan_rx_test;

  localparam int MIN = 5;
  localparam int ACK = 6;
  localparam int GAP = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [29:0] in_data;
  logic        in_req, in_intr, buf_active, mem_grant;
  logic        in_ack, mem_req, mem_is_intr;
  logic [29:0] mem_word;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  inchan_rx #(.DATA_W(30), .MIN_DELAY_CYC(MIN), .ACK_CYC(ACK), .GAP_CYC(GAP)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_data_i     (in_data),
    .in_req_i      (in_req),
    .in_intr_i     (in_intr),
    .buf_active_i  (buf_active),
    .in_ack_o      (in_ack),
    .mem_req_o     (mem_req),
    .mem_grant_i   (mem_grant),
    .mem_word_o    (mem_word),
    .mem_is_intr_o (mem_is_intr)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // one full transaction; grant is driven high from edge gk+1 on
  task automatic xact(input bit is_intr, input bit both, input int gk,
                      input logic [29:0] w, input string tg);
    int n, ack_at, drop_at, g, e, wd;
    @(negedge clk);
    in_data   = w;
    in_intr   = is_intr;
    in_req    = !is_intr || both;
    mem_grant = (gk == 0);
    n = 0; ack_at = 0; drop_at = 0;
    while (ack_at == 0 && n < 100) begin
      @(posedge clk); #1; n++;
      if (n == 2) chk(mem_req === 1'b0, "R1", mem_req, 0);
      if (n == 3) chk(mem_req === 1'b1, "R1", mem_req, 1);
      if (n > 3 && drop_at == 0 && mem_req === 1'b0) drop_at = n;
      if (in_ack === 1'b1) begin
        ack_at = n;
        chk(mem_word === w, "R5", mem_word, w);
        chk(mem_is_intr === is_intr, tg, mem_is_intr, is_intr);
      end else begin
        @(negedge clk);
        mem_grant = (n >= gk);
      end
    end
    g = (gk + 1 > 4) ? gk + 1 : 4;
    e = (MIN + 4 > g + 1) ? MIN + 4 : g + 1;
    chk(drop_at == g, "R6", drop_at, g);
    chk(ack_at == e, "R7", ack_at, e);
    @(negedge clk);
    mem_grant = 1'b0;
    in_req    = 1'b0;
    in_intr   = 1'b0;
    in_data   = ~w;
    wd = 1;
    while (wd < 50) begin
      @(posedge clk); #1;
      if (in_ack !== 1'b1) break;
      wd++;
      chk(mem_word === w, "R5", mem_word, w);
    end
    chk(wd == ACK, "R8", wd, ACK);
    repeat (GAP + 2) @(negedge clk);
  endtask

  // drop the request for L cycles right after an acknowledge, then raise it
  task automatic gap_probe(input int L);
    bit seen_low, second;
    string tg;
    buf_active = 1'b1;
    mem_grant  = 1'b1;
    @(negedge clk);
    in_data = 30'(L * 1111);
    in_req  = 1'b1;
    while (in_ack !== 1'b1) begin
      @(posedge clk); #1;
    end
    @(negedge clk);
    in_req = 1'b0;
    repeat (L) @(negedge clk);
    in_req = 1'b1;
    seen_low = 1'b0;
    second   = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (in_ack !== 1'b1) seen_low = 1'b1;
      else if (seen_low) second = 1'b1;
    end
    tg = (L == GAP) ? "R10" : "R9";
    chk(second == (L >= GAP), tg, second, (L >= GAP));
    @(negedge clk);
    in_req = 1'b0;
    repeat (ACK + MIN + GAP + 12) @(negedge clk);
    mem_grant = 1'b0;
  endtask

  initial begin
    rst_n      = 1'b0;
    in_data    = '0;
    in_req     = 1'b0;
    in_intr    = 1'b0;
    buf_active = 1'b0;
    mem_grant  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(in_ack === 1'b0, "R11", in_ack, 0);
    chk(mem_req === 1'b0, "R11", mem_req, 0);

    // R11: ready at once after reset
    buf_active = 1'b1;
    xact(1'b0, 1'b0, 0, 30'h2aaa_5555, "R11");

    // R7/R6: sweep the grant arrival for data and interrupt transactions
    for (int gk = 0; gk <= MIN + 4; gk++) begin
      xact(1'b0, 1'b0, gk, 30'(gk * 30'h0123_4567 + 7), "R3");
      xact(1'b1, 1'b0, gk, 30'(gk * 30'h0765_4321 + 3), "R3");
    end

    // R2: data request with no buffer open is ignored
    buf_active = 1'b0;
    @(negedge clk);
    in_data = 30'h1fff_0000;
    in_req  = 1'b1;
    begin
      bit any;
      any = 1'b0;
      for (int i = 0; i < 30; i++) begin
        @(posedge clk); #1;
        if (mem_req === 1'b1 || in_ack === 1'b1) any = 1'b1;
      end
      chk(any == 1'b0, "R2", any, 0);
    end
    @(negedge clk);
    in_req = 1'b0;
    repeat (GAP + 3) @(negedge clk);

    // R3: interrupt with no buffer open still served
    xact(1'b1, 1'b0, 2, 30'h0abc_def0, "R3");
    xact(1'b1, 1'b0, 7, 30'h3fff_ffff, "R3");

    // R4: both lines high resolves to an interrupt
    buf_active = 1'b1;
    xact(1'b1, 1'b1, 1, 30'h1234_5678, "R4");
    xact(1'b1, 1'b1, 9, 30'h0000_0001, "R4");

    // R9/R10: low gap around the threshold
    for (int L = 1; L <= GAP + 2; L++) gap_probe(L);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule